// File: doc/BRIEF.md
# Banked Extended UART Register File

This block is the host-facing register file of a 16550-style serial port. A processor reaches it through an 8-bit data bus, a 3-bit offset and separate read and write strobes. It stores the usual line, FIFO, interrupt-enable, divisor, modem-control and scratch registers. It also passes the line-status, modem-status, interrupt-identification and receive-data values of the rest of the UART back to the bus. All stored values go out on dedicated configuration ports to the baud generator, shifters, FIFOs and interrupt logic, which are not part of this block.

Software reaches a second set of registers by writing a key byte (0xBF) into the line-control register. While that key is held, offset 2 becomes the extended-feature register. The top two bits of that register choose which of four banks appears at offsets 4 to 7. The banks hold the software flow-control characters, the receive and transmit FIFO thresholds, a writable enumeration byte and a read-only hardware ID. When the line-control register holds any other value, offsets 2 and 4 to 7 reach the ordinary registers again. The banked values and the enhanced-mode bit keep their contents and stay on the output ports.

Top module: `bxuart_regfile`

## Requirements
- R1: After reset, every stored register (line control, FIFO control, interrupt enable, divisor low and high, modem control, scratch, extended feature, all banked registers, enumeration) is 0, the extended window is closed and the read data is 0.
- R2: The extended window is open exactly while the line-control register (offset 3) holds 0xBF. Writing 0xBF opens it in the next cycle, and writing any other value to offset 3 closes it in the next cycle.
- R3: With the window open, offset 2 writes and reads the extended-feature register. With the window closed, a write to offset 2 goes to the FIFO-control output and leaves the feature register unchanged, and a read returns the interrupt-identification input.
- R4: Feature bits 7:6 select bank 0 (00), 1 (01), 2 (10) or 3 (11) for offsets 4 to 7. Feature bit 4 is the enhanced-mode enable, and the whole feature register keeps its value while the window is closed.
- R5: Bank 0 offsets 4, 5, 6, 7 store the first XON, second XON, first XOFF and second XOFF characters. They read back and drive their output ports.
- R6: Bank 1 offsets 4, 5, 6, 7 store the receive low threshold, receive high threshold, receive trigger level and transmit threshold. They read back and drive their output ports.
- R7: In bank 2, offset 4 is the writable enumeration byte and offset 5 reads the HW_ID parameter. Writes to offset 5 are ignored, and offsets 6 and 7 read 0.
- R8: In bank 3, every offset 4 to 7 reads 0, and a write there changes no register or output.
- R9: With the window closed, offset 4 is modem control (read/write) and offset 7 is scratch (read/write). Offset 5 reads the line-status input and offset 6 reads the modem-status input. Writes to 5 and 6 are ignored.
- R10: Banked registers and the enumeration byte keep their values while the window is closed. Writes at offsets 4 to 7 with the window closed never reach them.
- R11: While line-control bit 7 is set, offsets 0 and 1 are the divisor low and high bytes. Otherwise offset 1 is interrupt enable, offset 0 reads the receive-data input, and an offset-0 write raises the transmit strobe for exactly one cycle with the written byte on the transmit-data port.
- R12: The read data register loads the addressed value on a clock edge where the read strobe is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| rx_data_i | input | 8 | Receive data from the receive path |
| iir_i | input | 8 | Interrupt identification value |
| lsr_i | input | 8 | Line status value |
| msr_i | input | 8 | Modem status value |
| lcr_o | output | 8 | Line-control register |
| fcr_o | output | 8 | FIFO-control register |
| ier_o | output | 8 | Interrupt-enable register |
| divisor_o | output | 16 | Baud divisor {high, low} |
| mcr_o | output | 8 | Modem-control register |
| scratch_o | output | 8 | Scratch register |
| efr_o | output | 8 | Extended-feature register |
| window_open_o | output | 1 | Extended window open |
| xon1_o | output | 8 | First XON character |
| xon2_o | output | 8 | Second XON character |
| xoff1_o | output | 8 | First XOFF character |
| xoff2_o | output | 8 | Second XOFF character |
| rx_lo_thr_o | output | 8 | Receive low threshold |
| rx_hi_thr_o | output | 8 | Receive high threshold |
| rx_trig_o | output | 8 | Receive trigger level |
| tx_thr_o | output | 8 | Transmit threshold |
| enum_o | output | 8 | Enumeration byte |
| tx_push_o | output | 1 | One-cycle transmit strobe |
| tx_data_o | output | 8 | Transmit byte |

## Verification
The decoder is driven with the same offsets under every combination of window state, bank selection and divisor-access bit. Each result shows which register a given offset reached. Distinct byte values are written into each bank and into the ordinary registers at the shared offsets. A misrouted write then shows up as a wrong value on a neighbour's output or readback. The bench closes and reopens the window to tell a held value from one that was reset or overwritten. Writes into the read-only ID, the status offsets and bank 3 are followed by readbacks and port checks, which confirm that those writes were inert.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int REG_W        = 8;
  localparam int OFF_W        = 3;
  localparam int BANK_SLOTS   = 4;
  localparam int NUM_BANKS    = 4;
  localparam int STORED_BANKS = 2;
  localparam int BANK_SEL_W   = $clog2(NUM_BANKS);
  localparam int SLOT_W       = $clog2(BANK_SLOTS);

  typedef enum logic [3:0] {
    TGT_NONE, TGT_DATA, TGT_IER, TGT_DLL, TGT_DLM, TGT_FCR_IIR, TGT_EFR,
    TGT_LCR, TGT_MCR, TGT_LSR, TGT_MSR, TGT_SCR, TGT_BANK, TGT_ENUM, TGT_ID
  } tgt_e;

  function automatic logic key_match(input logic [REG_W-1:0] lcr,
                                     input logic [REG_W-1:0] key);
    return lcr == key;
  endfunction

  function automatic logic [BANK_SEL_W-1:0] bank_of(input logic [REG_W-1:0] efr);
    return efr[REG_W-1 -: BANK_SEL_W];
  endfunction

  function automatic tgt_e map_target(input logic [OFF_W-1:0] off,
                                      input logic win,
                                      input logic dlab,
                                      input logic [BANK_SEL_W-1:0] bank);
    tgt_e t;
    t = TGT_NONE;
    case (off)
      3'd0: t = dlab ? TGT_DLL : TGT_DATA;
      3'd1: t = dlab ? TGT_DLM : TGT_IER;
      3'd2: t = win ? TGT_EFR : TGT_FCR_IIR;
      3'd3: t = TGT_LCR;
      default: begin
        if (!win) begin
          case (off[1:0])
            2'd0: t = TGT_MCR;
            2'd1: t = TGT_LSR;
            2'd2: t = TGT_MSR;
            default: t = TGT_SCR;
          endcase
        end else begin
          case (bank)
            2'd0, 2'd1: t = TGT_BANK;
            2'd2: begin
              if (off[1:0] == 2'd0)      t = TGT_ENUM;
              else if (off[1:0] == 2'd1) t = TGT_ID;
              else                       t = TGT_NONE;
            end
            default: t = TGT_NONE;
          endcase
        end
      end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/bxu_addr_decode.sv
module bxu_addr_decode
  import bxu_pkg::*;
#(
  parameter logic [REG_W-1:0] WIN_KEY = 8'hBF
) (
  input  logic [OFF_W-1:0]      off_i,
  input  logic [REG_W-1:0]      lcr_i,
  input  logic [REG_W-1:0]      efr_i,
  output tgt_e                  tgt_o,
  output logic                  win_o,
  output logic [BANK_SEL_W-1:0] bank_o,
  output logic [SLOT_W-1:0]     slot_o
);
  logic dlab;

  always_comb begin
    win_o  = key_match(lcr_i, WIN_KEY);
    dlab   = lcr_i[REG_W-1];
    bank_o = bank_of(efr_i);
    slot_o = off_i[SLOT_W-1:0];
    tgt_o  = map_target(off_i, win_o, dlab, bank_o);
  end
endmodule

// File: rtl/bxu_bank_store.sv
module bxu_bank_store
  import bxu_pkg::*;
#(
  parameter int SLOTS = BANK_SLOTS
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic [REG_W-1:0]                 wdata_i,
  output logic [SLOTS-1:0][REG_W-1:0]      regs_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = we_i && (slot_i == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs_o[s] <= '0;
      else if (hit) regs_o[s] <= wdata_i;
    end
  end
endmodule

// File: rtl/bxu_ctrl_regs.sv
module bxu_ctrl_regs
  import bxu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  tgt_e             tgt_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] lcr_o,
  output logic [REG_W-1:0] efr_o,
  output logic [REG_W-1:0] fcr_o,
  output logic [REG_W-1:0] ier_o,
  output logic [REG_W-1:0] dll_o,
  output logic [REG_W-1:0] dlm_o,
  output logic [REG_W-1:0] mcr_o,
  output logic [REG_W-1:0] scr_o,
  output logic [REG_W-1:0] enum_o,
  output logic             tx_push_o,
  output logic [REG_W-1:0] tx_data_o
);
  logic push_hit;
  assign push_hit = we_i && (tgt_i == TGT_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_o <= '0; efr_o <= '0; fcr_o <= '0; ier_o <= '0;
      dll_o <= '0; dlm_o <= '0; mcr_o <= '0; scr_o <= '0;
      enum_o <= '0; tx_push_o <= 1'b0; tx_data_o <= '0;
    end else begin
      tx_push_o <= push_hit;
      if (push_hit) tx_data_o <= wdata_i;
      if (we_i) begin
        case (tgt_i)
          TGT_LCR:     lcr_o  <= wdata_i;
          TGT_EFR:     efr_o  <= wdata_i;
          TGT_FCR_IIR: fcr_o  <= wdata_i;
          TGT_IER:     ier_o  <= wdata_i;
          TGT_DLL:     dll_o  <= wdata_i;
          TGT_DLM:     dlm_o  <= wdata_i;
          TGT_MCR:     mcr_o  <= wdata_i;
          TGT_SCR:     scr_o  <= wdata_i;
          TGT_ENUM:    enum_o <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  // R3: a FIFO-control write must leave the feature register alone
  p_fcr_spares_efr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && tgt_i == TGT_FCR_IIR) |=> $stable(efr_o));
endmodule

// File: rtl/bxuart_regfile.sv
module bxuart_regfile
  import bxu_pkg::*;
#(
  parameter logic [REG_W-1:0] HW_ID   = 8'h02,
  parameter logic [REG_W-1:0] WIN_KEY = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [REG_W-1:0]  rx_data_i,
  input  logic [REG_W-1:0]  iir_i,
  input  logic [REG_W-1:0]  lsr_i,
  input  logic [REG_W-1:0]  msr_i,
  output logic [REG_W-1:0]  lcr_o,
  output logic [REG_W-1:0]  fcr_o,
  output logic [REG_W-1:0]  ier_o,
  output logic [2*REG_W-1:0] divisor_o,
  output logic [REG_W-1:0]  mcr_o,
  output logic [REG_W-1:0]  scratch_o,
  output logic [REG_W-1:0]  efr_o,
  output logic              window_open_o,
  output logic [REG_W-1:0]  xon1_o,
  output logic [REG_W-1:0]  xon2_o,
  output logic [REG_W-1:0]  xoff1_o,
  output logic [REG_W-1:0]  xoff2_o,
  output logic [REG_W-1:0]  rx_lo_thr_o,
  output logic [REG_W-1:0]  rx_hi_thr_o,
  output logic [REG_W-1:0]  rx_trig_o,
  output logic [REG_W-1:0]  tx_thr_o,
  output logic [REG_W-1:0]  enum_o,
  output logic              tx_push_o,
  output logic [REG_W-1:0]  tx_data_o
);
  localparam int SB_W = $clog2(STORED_BANKS);

  tgt_e                   tgt;
  logic                   win;
  logic [BANK_SEL_W-1:0]  bank;
  logic [SLOT_W-1:0]      slot;
  logic [REG_W-1:0]       dll, dlm, rd_next;
  logic [STORED_BANKS-1:0][BANK_SLOTS-1:0][REG_W-1:0] bank_q;

  bxu_addr_decode #(.WIN_KEY(WIN_KEY)) u_dec (
    .off_i(addr_i), .lcr_i(lcr_o), .efr_i(efr_o),
    .tgt_o(tgt), .win_o(win), .bank_o(bank), .slot_o(slot)
  );

  bxu_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en_i), .tgt_i(tgt), .wdata_i(wdata_i),
    .lcr_o(lcr_o), .efr_o(efr_o), .fcr_o(fcr_o), .ier_o(ier_o),
    .dll_o(dll), .dlm_o(dlm), .mcr_o(mcr_o), .scr_o(scratch_o),
    .enum_o(enum_o), .tx_push_o(tx_push_o), .tx_data_o(tx_data_o)
  );

  for (genvar b = 0; b < STORED_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en_i && (tgt == TGT_BANK) && (bank == BANK_SEL_W'(b));
    bxu_bank_store #(.SLOTS(BANK_SLOTS)) u_store (
      .clk(clk), .rst_n(rst_n), .we_i(bank_we), .slot_i(slot),
      .wdata_i(wdata_i), .regs_o(bank_q[b])
    );
  end

  assign window_open_o = win;
  assign divisor_o     = {dlm, dll};
  assign xon1_o      = bank_q[0][0];
  assign xon2_o      = bank_q[0][1];
  assign xoff1_o     = bank_q[0][2];
  assign xoff2_o     = bank_q[0][3];
  assign rx_lo_thr_o = bank_q[1][0];
  assign rx_hi_thr_o = bank_q[1][1];
  assign rx_trig_o   = bank_q[1][2];
  assign tx_thr_o    = bank_q[1][3];

  always_comb begin
    case (tgt)
      TGT_DATA:    rd_next = rx_data_i;
      TGT_IER:     rd_next = ier_o;
      TGT_DLL:     rd_next = dll;
      TGT_DLM:     rd_next = dlm;
      TGT_FCR_IIR: rd_next = iir_i;
      TGT_EFR:     rd_next = efr_o;
      TGT_LCR:     rd_next = lcr_o;
      TGT_MCR:     rd_next = mcr_o;
      TGT_LSR:     rd_next = lsr_i;
      TGT_MSR:     rd_next = msr_i;
      TGT_SCR:     rd_next = scratch_o;
      TGT_BANK:    rd_next = bank_q[bank[SB_W-1:0]][slot];
      TGT_ENUM:    rd_next = enum_o;
      TGT_ID:      rd_next = HW_ID;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  // R2: key write opens, any other line-control write closes
  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd3 && wdata_i == WIN_KEY) |=> window_open_o);
  p_other_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 3'd3 && wdata_i != WIN_KEY) |=> !window_open_o);
  // R4: feature register frozen while the window is closed
  p_efr_persist_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !window_open_o |=> $stable(efr_o));
  // R10: banked contents frozen while the window is closed
  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !window_open_o |=> $stable({xon1_o, xon2_o, xoff1_o, xoff2_o, rx_lo_thr_o,
                                rx_hi_thr_o, rx_trig_o, tx_thr_o, enum_o}));
  // R8: bank 3 writes are inert
  p_bank3_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open_o && efr_o[7:6] == 2'b11 && wr_en_i && addr_i[2])
      |=> $stable({xon1_o, xon2_o, xoff1_o, xoff2_o, rx_lo_thr_o, rx_hi_thr_o,
                   rx_trig_o, tx_thr_o, enum_o, mcr_o, scratch_o}));
  // R11: transmit strobe only follows an offset-0 write without divisor access
  p_push_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_o |-> $past(wr_en_i && addr_i == 3'd0 && !lcr_o[7]));
  // R12: read data holds without a read strobe
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/bxuart_regfile_tb_top.sv
module bxuart_regfile_tb_top;
  localparam logic [7:0] ID = 8'hA6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, rx_data, iir, lsr, msr;
  logic [7:0] lcr, fcr, ier, mcr, scr, efr, xon1, xon2, xoff1, xoff2;
  logic [7:0] rxlo, rxhi, rxtrig, txthr, enm, txd;
  logic [15:0] div;
  logic win, txp;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bxuart_regfile #(.HW_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .rdata_o(rdata), .rx_data_i(rx_data), .iir_i(iir),
    .lsr_i(lsr), .msr_i(msr), .lcr_o(lcr), .fcr_o(fcr), .ier_o(ier),
    .divisor_o(div), .mcr_o(mcr), .scratch_o(scr), .efr_o(efr),
    .window_open_o(win), .xon1_o(xon1), .xon2_o(xon2), .xoff1_o(xoff1),
    .xoff2_o(xoff2), .rx_lo_thr_o(rxlo), .rx_hi_thr_o(rxhi), .rx_trig_o(rxtrig),
    .tx_thr_o(txthr), .enum_o(enm), .tx_push_o(txp), .tx_data_o(txd)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: push the expected byte, then issue the read
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // monitor: compare each read result the cycle it appears
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk(16'(rdata), 16'hFFFF, "scoreboard underflow");
        else chk(16'(rdata), 16'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rx_data = 8'h9C; iir = 8'hC1; lsr = 8'h61; msr = 8'hB0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lcr, 0, "R1 lcr"); chk(efr, 0, "R1 efr"); chk(xon1, 0, "R1 xon1");
    chk(enm, 0, "R1 enum"); chk(div, 0, "R1 divisor"); chk(rdata, 0, "R1 rdata");
    chk(win, 0, "R1 window");
    rd(3'd3, 8'h00, "R1 lcr read");

    // R9 ordinary registers at shared offsets
    wr(3'd4, 8'h0B); chk(mcr, 8'h0B, "R9 mcr out");
    rd(3'd4, 8'h0B, "R9 mcr read");
    rd(3'd5, 8'h61, "R9 lsr read");
    wr(3'd5, 8'hFF); rd(3'd5, 8'h61, "R9 lsr write ignored");
    rd(3'd6, 8'hB0, "R9 msr read");
    wr(3'd7, 8'h3C); rd(3'd7, 8'h3C, "R9 scratch read");
    chk(xon1, 0, "R10 closed write misses bank");

    // R3 offset 2 closed
    wr(3'd2, 8'hC7); chk(fcr, 8'hC7, "R3 fcr out"); chk(efr, 0, "R3 efr untouched");
    rd(3'd2, 8'hC1, "R3 iir read");

    // R2 open window, R5 bank 0
    wr(3'd3, 8'hBF); chk(win, 1, "R2 key opens");
    rd(3'd2, 8'h00, "R3 efr read");
    wr(3'd2, 8'h10);
    wr(3'd4, 8'h11); wr(3'd5, 8'h12); wr(3'd6, 8'h13); wr(3'd7, 8'h19);
    chk(xon1, 8'h11, "R5 xon1"); chk(xon2, 8'h12, "R5 xon2");
    chk(xoff1, 8'h13, "R5 xoff1"); chk(xoff2, 8'h19, "R5 xoff2");
    rd(3'd6, 8'h13, "R5 xoff1 read");
    chk(mcr, 8'h0B, "R5 mcr untouched"); chk(scr, 8'h3C, "R5 scratch untouched");

    // R6 bank 1
    wr(3'd2, 8'h50);
    wr(3'd4, 8'h04); wr(3'd5, 8'h30); wr(3'd6, 8'h20); wr(3'd7, 8'h08);
    chk(rxlo, 8'h04, "R6 rx low"); chk(rxhi, 8'h30, "R6 rx high");
    chk(rxtrig, 8'h20, "R6 rx trig"); chk(txthr, 8'h08, "R6 tx thr");
    rd(3'd5, 8'h30, "R6 rx high read");
    chk(xon1, 8'h11, "R4 bank select keeps bank 0");

    // R7 bank 2
    wr(3'd2, 8'h90);
    wr(3'd4, 8'h5E); chk(enm, 8'h5E, "R7 enum out");
    rd(3'd4, 8'h5E, "R7 enum read");
    rd(3'd5, ID, "R7 id read");
    wr(3'd5, 8'h77); rd(3'd5, ID, "R7 id write ignored");
    rd(3'd6, 8'h00, "R7 slot 6 zero"); rd(3'd7, 8'h00, "R7 slot 7 zero");

    // R8 bank 3
    wr(3'd2, 8'hD0);
    wr(3'd4, 8'hEE); wr(3'd5, 8'hEE); wr(3'd6, 8'hEE); wr(3'd7, 8'hEE);
    rd(3'd4, 8'h00, "R8 bank3 read"); rd(3'd7, 8'h00, "R8 bank3 read 7");
    chk(xon1, 8'h11, "R8 xon1 kept"); chk(rxlo, 8'h04, "R8 rx low kept");
    chk(enm, 8'h5E, "R8 enum kept"); chk(mcr, 8'h0B, "R8 mcr kept");

    // R2 close, R4 persistence, R10 hold
    wr(3'd3, 8'h03); chk(win, 0, "R2 other value closes");
    chk(efr, 8'hD0, "R4 efr kept"); chk(efr[4], 1, "R4 enhanced bit kept");
    wr(3'd4, 8'h01); chk(mcr, 8'h01, "R9 mcr write");
    chk(xon1, 8'h11, "R10 xon1 held"); chk(rxlo, 8'h04, "R10 rx low held");
    rd(3'd4, 8'h01, "R9 mcr readback");
    wr(3'd2, 8'h07); chk(fcr, 8'h07, "R3 fcr"); chk(efr, 8'hD0, "R3 efr kept");
    wr(3'd3, 8'hBE); chk(win, 0, "R2 near key stays closed");
    wr(3'd3, 8'hBF); rd(3'd2, 8'hD0, "R4 efr after reopen");
    wr(3'd2, 8'h10); rd(3'd4, 8'h11, "R10 xon1 after reopen");

    // R11 divisor and data path
    wr(3'd0, 8'h34); chk(txp, 0, "R11 no push under divisor access");
    wr(3'd1, 8'h12); chk(div, 16'h1234, "R11 divisor");
    wr(3'd3, 8'h83); rd(3'd0, 8'h34, "R11 dll read"); rd(3'd1, 8'h12, "R11 dlm read");
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h0F); chk(ier, 8'h0F, "R11 ier"); chk(div, 16'h1234, "R11 divisor kept");
    rd(3'd0, 8'h9C, "R11 rx data read");
    wr(3'd0, 8'h5A); chk(txp, 1, "R11 push"); chk(txd, 8'h5A, "R11 tx data");
    @(negedge clk); chk(txp, 0, "R11 push one cycle");

    // R12 hold without read strobe
    rd(3'd7, 8'h3C, "R12 scratch read");
    @(negedge clk); addr = 3'd5;
    repeat (2) @(negedge clk);
    chk(rdata, 8'h3C, "R12 rdata held");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule